// File: doc/BRIEF.md
# Video Palette DAC Host Register File

This block is the host-facing control register file of a video palette digital-to-analog converter. A microprocessor reaches it through a 3-bit register-select code, an 8-bit write bus, an 8-bit read bus, and single-cycle read and write strobes. Three select codes reach directly addressed registers: the pixel command register, and the low and high bytes of a 16-bit index pointer. A fourth code is a data window into an extended register space. The index pointer chooses which extended register the window reaches, and the window is open only while the command register's extended-space bit is set.

The extended space holds two fixed identity bytes, the primary and secondary pixel mode selectors, and a write-one soft-reset control. The block drives its decoded configuration straight to the neighbouring palette, converter and pixel-path logic: the color format, the feature enables and both mode selectors. Reserved bits and unused locations always read as zero. A soft reset returns the command register and the index pointer to their power-on values and leaves the mode selectors unchanged.

Top module: `ramdac_ctl_regs`

## Requirements
- R1: After the power-on reset (`rst_n` low), the command register, both index bytes and both mode selectors are 00h, every configuration output is 0, and `host_rdata` is 00h.
- R2: A write (`host_wr` high at a rising edge) stores `host_wdata` at the location named by `host_sel`. Code 110 selects the command register, 100 the index low byte, 111 the index high byte and 101 the indexed data window. `host_rdata` is combinational. It shows the selected location while `host_rd` is high, and it is 00h while `host_rd` is low or for codes 000–011.
- R3: Command register fields, by bit position: [7:5] color format (000 8-bit indexed, 101 15-bit direct, 110 16-bit direct, 111 24-bit direct), [4] extended-space enable, [3] extended pixel modes, [2] blanking pedestal, [1] 8-bit palette data, [0] sleep request. Each field drives its output from the cycle after the write. A write carrying a reserved format code (001–100) leaves bits [7:5] unchanged and still updates bits [4:0].
- R4: Through the window, index 0000h reads 97h and index 0001h reads 03h. Writes to these two indexes change nothing.
- R5: Indexes 0003h and 0004h hold the primary and secondary mode selectors and drive `mode_primary` and `mode_secondary`. A write of 00h–09h is stored. A write of 0Ah–FFh is ignored.
- R6: While command bit [4] is 0, window reads return 00h and window writes change nothing.
- R7: Undefined indexes (0002h, 0005h, 0007h and above, and any index with a nonzero high byte) read 00h and ignore writes. Index 0006h always reads 00h.
- R8: A window write to index 0006h with bit [0] set arms a one-cycle soft-reset pulse. At the next rising edge, the command register and both index bytes return to 00h, and the mode selectors keep their values. Writing 0 to bit [0] has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| host_sel | input | 3 | Register-select code |
| host_wdata | input | 8 | Host write data |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_rd | input | 1 | Read strobe, qualifies host_rdata |
| host_rdata | output | 8 | Read data, 00h when not reading |
| pix_fmt | output | 3 | Color format code |
| ext_regs_en | output | 1 | Extended register space enabled |
| ext_pix_en | output | 1 | Extended pixel modes enabled |
| pedestal_en | output | 1 | Blanking pedestal enabled |
| dac_8bit | output | 1 | Palette data is 8 bits wide rather than 6 |
| sleep_req | output | 1 | Sleep mode request |
| mode_primary | output | 8 | Primary pixel mode selector |
| mode_secondary | output | 8 | Secondary pixel mode selector |

## Verification
The assertions assume that the host strobes are clean single-cycle levels sampled at the rising edge, and that the reset is the only source of an unknown state. They also assume the host does not write to the index bytes or the command register in the pulse cycle that follows a soft-reset request. The stimulus changes inputs two time units after each rising edge and raises at most one strobe at a time. In the soft-reset sequence it leaves the cycle after the arming write idle, so the restored values are observed without a competing write.

// File: rtl/ramdac_pkg.sv
package ramdac_pkg;

   // Legal color format codes held in the command register
   typedef enum logic [2:0] {
      FMT_IDX8 = 3'b000,
      FMT_DC15 = 3'b101,
      FMT_DC16 = 3'b110,
      FMT_DC24 = 3'b111
   } pix_fmt_e;

   // Host select codes
   localparam logic [2:0] SEL_IDX_LO  = 3'b100;
   localparam logic [2:0] SEL_IDX_DAT = 3'b101;
   localparam logic [2:0] SEL_CMD     = 3'b110;
   localparam logic [2:0] SEL_IDX_HI  = 3'b111;

   // Command register bit positions
   localparam int CMD_FMT_LSB   = 5;
   localparam int CMD_EXT_SPACE = 4;
   localparam int CMD_EXT_PIX   = 3;
   localparam int CMD_PEDESTAL  = 2;
   localparam int CMD_DAC8      = 1;
   localparam int CMD_SLEEP     = 0;

   function automatic logic fmt_legal(input logic [2:0] f);
      logic ok;
      case (f)
         FMT_IDX8, FMT_DC15, FMT_DC16, FMT_DC24: ok = 1'b1;
         default:                                ok = 1'b0;
      endcase
      return ok;
   endfunction

endpackage

// File: rtl/ramdac_host_dec.sv
module ramdac_host_dec
   import ramdac_pkg::*;
(
   input  logic [2:0] sel,
   input  logic       wr,
   input  logic       rd,
   output logic       we_cmd,
   output logic [1:0] we_idx,
   output logic       we_dat,
   output logic       re_cmd,
   output logic [1:0] re_idx,
   output logic       re_dat
);

   logic hit_cmd, hit_lo, hit_hi, hit_dat;

   always_comb begin
      hit_cmd = (sel == SEL_CMD);
      hit_lo  = (sel == SEL_IDX_LO);
      hit_hi  = (sel == SEL_IDX_HI);
      hit_dat = (sel == SEL_IDX_DAT);
   end

   always_comb begin
      we_cmd = wr & hit_cmd;
      we_idx = {wr & hit_hi, wr & hit_lo};
      we_dat = wr & hit_dat;
      re_cmd = rd & hit_cmd;
      re_idx = {rd & hit_hi, rd & hit_lo};
      re_dat = rd & hit_dat;
   end

endmodule

// File: rtl/ramdac_ptr_cmd.sv
module ramdac_ptr_cmd
   import ramdac_pkg::*;
#(
   parameter int DW    = 8,
   parameter int IDX_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                srst,
   input  logic                we_cmd,
   input  logic [IDX_W/DW-1:0] we_idx,
   input  logic [DW-1:0]       wdata,
   output logic [DW-1:0]       cmd_q,
   output logic [IDX_W-1:0]    idx_q
);

   localparam int NBYTE = IDX_W / DW;

   logic [2:0] fmt_nx;

   // A reserved format code keeps the stored format
   always_comb begin
      fmt_nx = fmt_legal(wdata[CMD_FMT_LSB +: 3]) ? wdata[CMD_FMT_LSB +: 3]
                                                  : cmd_q[CMD_FMT_LSB +: 3];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      cmd_q <= '0;
      else if (srst)   cmd_q <= '0;
      else if (we_cmd) cmd_q <= {fmt_nx, wdata[CMD_FMT_LSB-1:0]};
   end

   // One byte lane of the index pointer per host select code
   for (genvar b = 0; b < NBYTE; b++) begin : g_lane
      always_ff @(posedge clk) begin
         if (!rst_n)         idx_q[b*DW +: DW] <= '0;
         else if (srst)      idx_q[b*DW +: DW] <= '0;
         else if (we_idx[b]) idx_q[b*DW +: DW] <= wdata;
      end
   end

   // R3: the stored format is always a legal code
   p_fmt_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fmt_legal(cmd_q[CMD_FMT_LSB +: 3]));

   // R8: the soft-reset pulse restores command and pointer
   p_srst_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> (cmd_q == '0 && idx_q == '0));

endmodule

// File: rtl/ramdac_ext_regs.sv
module ramdac_ext_regs #(
   parameter int            DW        = 8,
   parameter int            IDX_W     = 16,
   parameter int            NUM_MODE  = 2,
   parameter int            MODE_BASE = 3,
   parameter int            MODE_MAX  = 9,
   parameter int            SRST_IDX  = 6,
   parameter logic [DW-1:0] ID0_VAL   = 8'h97,
   parameter logic [DW-1:0] ID1_VAL   = 8'h03
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         ext_en,
   input  logic [IDX_W-1:0]             idx,
   input  logic                         we_dat,
   input  logic [DW-1:0]                wdata,
   output logic [DW-1:0]                rd_val,
   output logic [NUM_MODE-1:0][DW-1:0]  mode_q,
   output logic                         srst
);

   localparam logic [IDX_W-1:0] ID0_IDX  = '0;
   localparam logic [IDX_W-1:0] ID1_IDX  = IDX_W'(1);
   localparam logic [IDX_W-1:0] SRST_AT  = IDX_W'(SRST_IDX);
   localparam logic [DW-1:0]    MODE_LIM = DW'(MODE_MAX);

   logic wr_ok;
   logic srst_q;

   always_comb wr_ok = we_dat & ext_en;

   // Self-clearing pulse: armed by the write, gone one cycle later
   always_ff @(posedge clk) begin
      if (!rst_n) srst_q <= 1'b0;
      else        srst_q <= !srst_q && wr_ok && (idx == SRST_AT) && wdata[0];
   end
   assign srst = srst_q;

   for (genvar i = 0; i < NUM_MODE; i++) begin : g_mode
      localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(MODE_BASE + i);
      always_ff @(posedge clk) begin
         if (!rst_n)
            mode_q[i] <= '0;
         else if (wr_ok && idx == MY_IDX && wdata <= MODE_LIM)
            mode_q[i] <= wdata;
      end

      // R5: a reserved mode value is never stored
      p_mode_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
         mode_q[i] <= MODE_LIM);
   end

   always_comb begin
      rd_val = '0;
      if (ext_en) begin
         if (idx == ID0_IDX) rd_val = ID0_VAL;
         if (idx == ID1_IDX) rd_val = ID1_VAL;
         for (int i = 0; i < NUM_MODE; i++)
            if (idx == IDX_W'(MODE_BASE + i)) rd_val = mode_q[i];
      end
   end

   // R8: the soft-reset request lasts exactly one cycle
   p_srst_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      srst_q |=> !srst_q);

   // R6: a closed window leaves the mode selectors alone
   p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (we_dat && !ext_en) |=> $stable(mode_q));

endmodule

// File: rtl/ramdac_ctl_regs.sv
module ramdac_ctl_regs
   import ramdac_pkg::*;
#(
   parameter int            DW        = 8,
   parameter int            IDX_W     = 16,
   parameter int            MODE_BASE = 3,
   parameter int            MODE_MAX  = 9,
   parameter int            SRST_IDX  = 6,
   parameter logic [DW-1:0] VENDOR_ID = 8'h97,
   parameter logic [DW-1:0] DEVICE_ID = 8'h03
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [2:0]    host_sel,
   input  logic [DW-1:0] host_wdata,
   input  logic          host_wr,
   input  logic          host_rd,
   output logic [DW-1:0] host_rdata,
   output logic [2:0]    pix_fmt,
   output logic          ext_regs_en,
   output logic          ext_pix_en,
   output logic          pedestal_en,
   output logic          dac_8bit,
   output logic          sleep_req,
   output logic [DW-1:0] mode_primary,
   output logic [DW-1:0] mode_secondary
);

   localparam int NUM_MODE = 2;
   localparam int NBYTE    = IDX_W / DW;

   // Elaboration-time parameter checks
   if (DW != 8) begin : g_bad_dw
      $error("ramdac_ctl_regs: DW must be 8");
   end
   if (NBYTE != 2 || IDX_W % DW != 0) begin : g_bad_idx
      $error("ramdac_ctl_regs: IDX_W must be two data bytes");
   end
   if (MODE_MAX < 0 || MODE_MAX >= (1 << DW)) begin : g_bad_max
      $error("ramdac_ctl_regs: MODE_MAX out of range");
   end
   if (SRST_IDX < 2 || (SRST_IDX >= MODE_BASE && SRST_IDX < MODE_BASE + NUM_MODE)) begin : g_bad_srst
      $error("ramdac_ctl_regs: SRST_IDX collides with another register");
   end

   logic                         we_cmd, we_dat, re_cmd, re_dat;
   logic [1:0]                   we_idx, re_idx;
   logic                         srst;
   logic [DW-1:0]                cmd_q;
   logic [IDX_W-1:0]             idx_q;
   logic [DW-1:0]                ext_rd;
   logic [NUM_MODE-1:0][DW-1:0]  mode_q;

   ramdac_host_dec u_dec (
      .sel    (host_sel),
      .wr     (host_wr),
      .rd     (host_rd),
      .we_cmd (we_cmd),
      .we_idx (we_idx),
      .we_dat (we_dat),
      .re_cmd (re_cmd),
      .re_idx (re_idx),
      .re_dat (re_dat)
   );

   ramdac_ptr_cmd #(.DW(DW), .IDX_W(IDX_W)) u_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .srst   (srst),
      .we_cmd (we_cmd),
      .we_idx (we_idx),
      .wdata  (host_wdata),
      .cmd_q  (cmd_q),
      .idx_q  (idx_q)
   );

   ramdac_ext_regs #(
      .DW        (DW),
      .IDX_W     (IDX_W),
      .NUM_MODE  (NUM_MODE),
      .MODE_BASE (MODE_BASE),
      .MODE_MAX  (MODE_MAX),
      .SRST_IDX  (SRST_IDX),
      .ID0_VAL   (VENDOR_ID),
      .ID1_VAL   (DEVICE_ID)
   ) u_ext (
      .clk    (clk),
      .rst_n  (rst_n),
      .ext_en (cmd_q[CMD_EXT_SPACE]),
      .idx    (idx_q),
      .we_dat (we_dat),
      .wdata  (host_wdata),
      .rd_val (ext_rd),
      .mode_q (mode_q),
      .srst   (srst)
   );

   // Read-back mux: zero unless a read strobe names a populated location
   always_comb begin
      host_rdata = '0;
      if (re_cmd)         host_rdata = cmd_q;
      else if (re_idx[0]) host_rdata = idx_q[0 +: DW];
      else if (re_idx[1]) host_rdata = idx_q[DW +: DW];
      else if (re_dat)    host_rdata = ext_rd;
   end

   always_comb begin
      pix_fmt        = cmd_q[CMD_FMT_LSB +: 3];
      ext_regs_en    = cmd_q[CMD_EXT_SPACE];
      ext_pix_en     = cmd_q[CMD_EXT_PIX];
      pedestal_en    = cmd_q[CMD_PEDESTAL];
      dac_8bit       = cmd_q[CMD_DAC8];
      sleep_req      = cmd_q[CMD_SLEEP];
      mode_primary   = mode_q[0];
      mode_secondary = mode_q[1];
   end

endmodule

// File: tb/sim_ramdac_ctl_regs.sv
`timescale 1ns/1ps
module sim_ramdac_ctl_regs;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] host_sel = 3'd0;
   logic [7:0] host_wdata = 8'd0;
   logic       host_wr = 1'b0;
   logic       host_rd = 1'b0;
   logic [7:0] host_rdata;
   logic [2:0] pix_fmt;
   logic       ext_regs_en, ext_pix_en, pedestal_en, dac_8bit, sleep_req;
   logic [7:0] mode_primary, mode_secondary;

   int n_chk = 0;
   int n_fail = 0;

   // Reference model state
   int m_cmd = 0, m_lo = 0, m_hi = 0, m_md0 = 0, m_md1 = 0, m_pend = 0;

   always #5 clk = ~clk;

   ramdac_ctl_regs u0 (
      .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wdata(host_wdata),
      .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
      .pix_fmt(pix_fmt), .ext_regs_en(ext_regs_en), .ext_pix_en(ext_pix_en),
      .pedestal_en(pedestal_en), .dac_8bit(dac_8bit), .sleep_req(sleep_req),
      .mode_primary(mode_primary), .mode_secondary(mode_secondary)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int model_rd();
      int ext, idx, v;
      v = 0;
      if (host_rd) begin
         ext = (m_cmd >> 4) & 1;
         idx = m_hi * 256 + m_lo;
         case (host_sel)
            3'd6: v = m_cmd;
            3'd4: v = m_lo;
            3'd7: v = m_hi;
            3'd5: if (ext == 1) begin
                     if (idx == 0) v = 'h97;
                     else if (idx == 1) v = 'h03;
                     else if (idx == 3) v = m_md0;
                     else if (idx == 4) v = m_md1;
                  end
            default: v = 0;
         endcase
      end
      return v;
   endfunction

   // Behavioural model: next state from the inputs seen at each edge
   always @(posedge clk) begin
      int d, f, ext, idx, npend;
      if (!rst_n) begin
         m_cmd = 0; m_lo = 0; m_hi = 0; m_md0 = 0; m_md1 = 0; m_pend = 0;
      end else begin
         d = host_wdata; ext = (m_cmd >> 4) & 1; idx = m_hi * 256 + m_lo;
         npend = 0;
         if (host_wr) begin
            case (host_sel)
               3'd6: if (m_pend == 0) begin
                        f = d >> 5;
                        if (f == 0 || f >= 5) m_cmd = d;
                        else m_cmd = (m_cmd & 'hE0) | (d & 'h1F);
                     end
               3'd4: if (m_pend == 0) m_lo = d;
               3'd7: if (m_pend == 0) m_hi = d;
               3'd5: if (ext == 1) begin
                        if (idx == 3 && d <= 9) m_md0 = d;
                        if (idx == 4 && d <= 9) m_md1 = d;
                        if (idx == 6 && (d & 1) == 1 && m_pend == 0) npend = 1;
                     end
               default: ;
            endcase
         end
         if (m_pend == 1) begin
            m_cmd = 0; m_lo = 0; m_hi = 0;
         end
         m_pend = npend;
      end
   end

   // Compare every output against the model on every clock
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R2 rdata vs model", host_rdata, model_rd());
         chk("R3 pix_fmt vs model", pix_fmt, (m_cmd >> 5) & 7);
         chk("R3 flags vs model",
             {ext_regs_en, ext_pix_en, pedestal_en, dac_8bit, sleep_req}, m_cmd & 'h1F);
         chk("R5 mode_primary vs model", mode_primary, m_md0);
         chk("R5 mode_secondary vs model", mode_secondary, m_md1);
      end
   end

   task automatic wr(input logic [2:0] s, input logic [7:0] d);
      host_sel = s; host_wdata = d; host_wr = 1'b1;
      @(posedge clk); #2;
      host_wr = 1'b0; host_wdata = 8'd0;
   endtask

   task automatic rd_chk(input logic [2:0] s, input int exp, input string tag);
      host_sel = s; host_rd = 1'b1;
      @(negedge clk);
      chk(tag, host_rdata, exp);
      @(posedge clk); #2;
      host_rd = 1'b0;
   endtask

   task automatic set_idx(input int v);
      wr(3'd4, 8'(v & 255));
      wr(3'd7, 8'((v >> 8) & 255));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog R1 actual=timeout expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 cmd outputs", {pix_fmt, ext_regs_en, ext_pix_en, pedestal_en, dac_8bit, sleep_req}, 0);
      chk("R1 modes", {mode_primary, mode_secondary}, 0);
      chk("R1 rdata idle", host_rdata, 0);
      @(posedge clk); #2;
      rd_chk(3'd6, 'h00, "R1 cmd reads 00");

      // R3 fields and reserved format handling
      wr(3'd6, 8'hBF);
      chk("R3 fmt 15-bit", pix_fmt, 5);
      chk("R3 all flags set", {ext_regs_en, ext_pix_en, pedestal_en, dac_8bit, sleep_req}, 'h1F);
      rd_chk(3'd6, 'hBF, "R3 cmd readback");
      wr(3'd6, 8'h3E);
      rd_chk(3'd6, 'hBE, "R3 reserved fmt keeps 101");
      wr(3'd6, 8'hE4);
      chk("R3 fmt 24-bit", pix_fmt, 7);
      chk("R3 only pedestal", {ext_regs_en, ext_pix_en, pedestal_en, dac_8bit, sleep_req}, 'h04);

      // R2 direct registers
      wr(3'd4, 8'h34);
      wr(3'd7, 8'h12);
      rd_chk(3'd4, 'h34, "R2 index low");
      rd_chk(3'd7, 'h12, "R2 index high");
      rd_chk(3'd2, 'h00, "R2 unused select code");
      host_sel = 3'd7; @(negedge clk);
      chk("R2 no strobe gives 00", host_rdata, 0);
      @(posedge clk); #2;

      // R6 closed window
      wr(3'd6, 8'h00);
      set_idx('h0003);
      wr(3'd5, 8'h05);
      chk("R6 write ignored", mode_primary, 0);
      set_idx('h0000);
      rd_chk(3'd5, 'h00, "R6 read gives 00");

      // R4 identity bytes
      wr(3'd6, 8'h10);
      rd_chk(3'd5, 'h97, "R4 identity 0000h");
      wr(3'd5, 8'h55);
      rd_chk(3'd5, 'h97, "R4 identity unchanged");
      set_idx('h0001);
      rd_chk(3'd5, 'h03, "R4 identity 0001h");

      // R5 mode selectors
      set_idx('h0003);
      wr(3'd5, 8'h07);
      chk("R5 primary stored", mode_primary, 7);
      rd_chk(3'd5, 'h07, "R5 primary readback");
      wr(3'd5, 8'h0A);
      chk("R5 0Ah ignored", mode_primary, 7);
      wr(3'd5, 8'hFF);
      chk("R5 FFh ignored", mode_primary, 7);
      set_idx('h0004);
      wr(3'd5, 8'h09);
      chk("R5 secondary stored", mode_secondary, 9);

      // R7 undefined indexes
      set_idx('h0002);
      wr(3'd5, 8'h05);
      rd_chk(3'd5, 'h00, "R7 index 0002h");
      set_idx('h0103);
      wr(3'd5, 8'h02);
      rd_chk(3'd5, 'h00, "R7 nonzero high byte");
      chk("R7 mode untouched", mode_primary, 7);
      set_idx('h0006);
      rd_chk(3'd5, 'h00, "R7 index 0006h");

      // R8 soft reset
      wr(3'd5, 8'h00);
      @(posedge clk); #2;
      chk("R8 zero bit0 no effect", ext_regs_en, 1);
      wr(3'd5, 8'h01);
      chk("R8 pulse not yet applied", ext_regs_en, 1);
      @(posedge clk); #2;
      chk("R8 cmd restored", {pix_fmt, ext_regs_en, ext_pix_en, pedestal_en, dac_8bit, sleep_req}, 0);
      rd_chk(3'd7, 'h00, "R8 index high restored");
      rd_chk(3'd4, 'h00, "R8 index low restored");
      chk("R8 primary kept", mode_primary, 7);
      chk("R8 secondary kept", mode_secondary, 9);

      repeat (2) @(posedge clk);
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule